// File: doc/BRIEF.md
# Valley Switching Pulse Generator

This block decides when the power switch of a quasi-resonant flyback stage may turn on again. After the gate turns off, the auxiliary winding rings. An external comparator reports when that sensed voltage is below zero. Each time the comparator output goes from high to low, one ringing valley has been seen. The block counts these valleys within the current off-interval. When the count reaches the valley number that the efficiency lookup currently demands, it issues a one-clock turn-on request.

The comparator bit arrives asynchronously and is synchronised inside the block. The gate signal and the demanded valley number are synchronous to the block clock. The request output feeds a downstream frequency limiter, which makes the final decision.

Top module: `valley_pulse_gen`

## Requirements
- R1: After reset `turn_on_o` is low, and no request is issued until the first falling edge of `pwm_i` has been seen. Valleys before that edge are ignored.
- R2: `zc_i` passes through a two-flop synchroniser. Suppose `zc_i` falls just after rising clock edge P0, with `pwm_i` low. The valley is then counted at rising edge P3, and any resulting request is high in the clock cycle between P3 and P4.
- R3: Each high-to-low transition of the synchronised `zc_i` while `pwm_i` is low adds exactly one to the valley count.
- R4: Every falling edge of `pwm_i` clears the valley count to zero and arms the block for a new off-interval.
- R5: `turn_on_o` is high for exactly one clock cycle per request.
- R6: At most one request is issued per off-interval. This holds even if further valleys follow, and even if `valley_dem_i` is later changed to match a later count.
- R7: No request is issued while `pwm_i` is high, and valleys seen while `pwm_i` is high do not count.
- R8: The valley count saturates at 2^CNT_W-1 (15 by default) instead of wrapping.
- R9: A `valley_dem_i` value of 0 requests the first valley.
- R10: `valley_dem_i` is compared combinationally with the current count. An armed block whose count already equals a newly applied demand raises `turn_on_o` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Gate drive signal, high while the switch is on |
| zc_i | input | 1 | Asynchronous comparator bit, high while the sensed winding voltage is below zero |
| valley_dem_i | input | CNT_W | Demanded valley number (0 is treated as 1) |
| turn_on_o | output | 1 | One-cycle turn-on request |

## Verification
A wrong valley count shows up at the port as a request that is early or late by whole valleys, or one that never comes. Each ringing period lasts eight clocks, so the error appears within one period of the demanded valley. A synchroniser or edge-detector fault shifts the request by a clock within the valley window. That shift is caught because the position of the pulse is checked, not only its presence. A stuck arming flag shows as a second pulse in the same off-interval, or as a pulse before the first gate turn-off. A wrapping counter shows as a pulse at valley 2^CNT_W+1, or as no pulse when the demand is raised to the saturated value.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  typedef struct packed {
    logic zc_fall;
    logic pwm_fall;
  } edges_t;
endpackage

// File: rtl/vpg_sync.sv
module vpg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/vpg_edge_det.sv
module vpg_edge_det (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            zc_s_i,
  input  logic            pwm_i,
  output vpg_pkg::edges_t edges_o
);
  logic zc_q, pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zc_q  <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      zc_q  <= zc_s_i;
      pwm_q <= pwm_i;
    end
  end

  assign edges_o.zc_fall  = zc_q & ~zc_s_i;
  assign edges_o.pwm_fall = pwm_q & ~pwm_i;
endmodule

// File: rtl/vpg_valley_cnt.sv
module vpg_valley_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  vpg_pkg::edges_t  edges_i,
  input  logic [CNT_W-1:0] valley_dem_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             turn_on_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, target;
  logic             armed_q, hit;

  // demand 0 maps to the first valley
  assign target = (valley_dem_i == '0) ? CNT_ONE : valley_dem_i;
  assign hit    = armed_q & ~pwm_i & ~edges_i.pwm_fall & (cnt_q == target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (edges_i.pwm_fall) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (~pwm_i && edges_i.zc_fall && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      if (hit) armed_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign armed_o   = armed_q;
  assign turn_on_o = hit;
endmodule

// File: rtl/valley_pulse_gen.sv
module valley_pulse_gen #(
  parameter int CNT_W     = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             zc_i,
  input  logic [CNT_W-1:0] valley_dem_i,
  output logic             turn_on_o
);
  logic             zc_s;
  vpg_pkg::edges_t  edges;
  logic [CNT_W-1:0] cnt;
  logic             armed;

  vpg_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (zc_i),
    .q_o   (zc_s)
  );

  vpg_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zc_s_i (zc_s),
    .pwm_i  (pwm_i),
    .edges_o(edges)
  );

  vpg_valley_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwm_i       (pwm_i),
    .edges_i     (edges),
    .valley_dem_i(valley_dem_i),
    .cnt_o       (cnt),
    .armed_o     (armed),
    .turn_on_o   (turn_on_o)
  );
endmodule

// File: rtl/vpg_checker.sv
module vpg_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwm_i,
  input logic             turn_on_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             armed_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_single_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_on_o |=> !turn_on_o);

  assert_quiet_on_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_i |-> !turn_on_o);

  assert_needs_arm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !turn_on_o);

  assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0));

  assert_clear_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_i) |=> (cnt_i == '0 && armed_i));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX && !$fell(pwm_i)) |=> cnt_i == CNT_MAX);
endmodule

bind valley_pulse_gen vpg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwm_i    (pwm_i),
  .turn_on_o(turn_on_o),
  .cnt_i    (cnt),
  .armed_i  (armed)
);

// File: tb/tb_valley_pulse_gen.sv
module tb_valley_pulse_gen;
  localparam int CNT_W = 4;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pwm_i = 1'b0;
  logic             zc_i = 1'b0;
  logic [CNT_W-1:0] valley_dem_i = '0;
  logic             turn_on_o;

  int n_run = 0, n_fail = 0, cyc = 0;

  valley_pulse_gen #(.CNT_W(CNT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i), .zc_i(zc_i),
    .valley_dem_i(valley_dem_i), .turn_on_o(turn_on_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input int got, input int exp, input string what);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic drive_tick();
    @(posedge clk_i); #1;
  endtask

  // one ringing period: 4 clocks high, 4 clocks low; pulses counted and last position
  task automatic valley(output int pulses, output int pos);
    pulses = 0; pos = 0;
    zc_i = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk_i);
      if (turn_on_o) begin pulses++; pos = 10 + i; end
    end
    drive_tick();
    zc_i = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk_i);
      if (turn_on_o) begin pulses++; pos = i; end
    end
    drive_tick();
  endtask

  task automatic pwm_fall();
    pwm_i = 1'b1; drive_tick(); drive_tick();
    pwm_i = 1'b0; drive_tick(); drive_tick();
  endtask

  // n valleys in current off-interval; chase keeps demand away from the count
  task automatic run_valleys(input int n, input int dem, input bit chase, input bit armed,
                             input string req);
    int t, p, at;
    t = (dem == 0) ? 1 : dem;
    for (int k = 1; k <= n; k++) begin
      if (chase) valley_dem_i = CNT_W'((k <= 14) ? k + 1 : 1);
      else       valley_dem_i = CNT_W'(dem);
      valley(p, at);
      if (chase) begin
        check(p, 0, $sformatf("%s R8 chase valley %0d pulses", req, k));
      end else if (armed && k == t) begin
        check(p, 1, $sformatf("%s R3 R5 dem %0d valley %0d pulses", req, dem, k));
        check(at, 4, $sformatf("%s R2 dem %0d pulse position", req, dem));
      end else begin
        check(p, 0, $sformatf("%s R6 dem %0d valley %0d pulses", req, dem, k));
      end
    end
  endtask

  initial begin
    int p, at;
    #2;
    check(turn_on_o, 0, "R1 output during reset");
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    drive_tick();
    // R1: unarmed until first PWM falling edge
    run_valleys(3, 1, 1'b0, 1'b0, "R1 pre-arm");

    // R3 R4 R9: sweep every demand, a fresh off-interval each
    for (int d = 0; d <= MAXV; d++) begin
      pwm_fall();
      run_valleys(((d == 0) ? 1 : d) + 2, d, 1'b0, 1'b1, (d == 0) ? "R9 R4" : "R4");
    end

    // R6: raise demand after firing, no second pulse
    pwm_fall();
    run_valleys(2, 2, 1'b0, 1'b1, "R6");
    valley_dem_i = 4;
    for (int k = 0; k < 4; k++) begin
      valley(p, at);
      check(p, 0, "R6 later match after fire");
    end

    // R7: valleys while PWM high give no request and do not count
    pwm_fall();
    run_valleys(2, 3, 1'b0, 1'b1, "R7 part");
    pwm_i = 1'b1; drive_tick();
    for (int k = 0; k < 3; k++) begin
      valley(p, at);
      check(p, 0, "R7 valley while pwm high");
    end
    pwm_i = 1'b0; drive_tick(); drive_tick();
    run_valleys(3, 3, 1'b0, 1'b1, "R7 R4 after high");

    // R8 R10: saturate then raise demand to max, immediate pulse
    pwm_fall();
    run_valleys(17, 0, 1'b1, 1'b1, "R8");
    valley_dem_i = CNT_W'(MAXV);
    @(negedge clk_i);
    check(turn_on_o, 1, "R8 R10 saturated count meets new demand");
    @(negedge clk_i);
    check(turn_on_o, 0, "R5 pulse width one cycle");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule